// File: doc/BRIEF.md
# Pipeline Bypass and Stall Controller

This block holds the hazard logic of a five-stage in-order integer pipeline. The stages are fetch, decode, execute, memory and write-back. It sees only decoded fields. For the instruction in decode it gets the operation class and its two source register numbers. For each older instruction in execute, memory and write-back it gets the destination register and a write flag. For the instruction in execute it also gets a load flag. From these it decides, while the consumer sits in decode, where each operand must come from once the consumer reaches execute. It registers those decisions so that they line up with the consumer as it moves on. It also raises a stall when a value cannot be delivered in time.

Store instructions get their own treatment. The base-address operand of a store is needed in execute, but the store-data operand is not needed until the memory stage. A load that feeds only the data of the store right behind it therefore causes no stall. Its result is steered into the store-data path during the memory stage. A load that feeds the address costs one stall cycle. During a stall the surrounding pipeline holds its program counter and its fetch/decode register, and this block turns the decisions entering execute into a bubble.

Operation classes are encoded as 0 none, 1 ALU (reads both sources, writes a destination), 2 load (reads source A as base, writes a destination) and 3 store (reads source A as base and source B as data, writes nothing).

Top module: `hzd_bypass_ctrl`

## Requirements
- R1: When the instruction in execute writes a nonzero register that a decode-stage ALU, load or store reads as source A, or that an ALU reads as source B, and that producer is not a load, there is no stall and the matching select equals 2'b01 (execute/memory result) on the cycle after.
- R2: When only the instruction in memory writes a read nonzero source register, the matching select equals 2'b10 (memory/write-back result) on the cycle after. With no match the select is 2'b00 (register file). The value 2'b11 never appears.
- R3: When both the execute-stage and the memory-stage instructions write the same read register, the select on the cycle after is 2'b01, because the younger producer wins.
- R4: A load in execute whose destination is read by a decode-stage ALU (either source) or load (source A) raises stall in that same cycle. The following cycle, with the load now in memory, has no stall, so exactly one stall cycle results. The operand then selects 2'b10.
- R5: A load in execute whose destination is read only as the data operand of a decode-stage store does not stall. The source-B select stays 2'b00, and the store-data bypass output is 1 two cycles later, when the store is in the memory stage.
- R6: A load in execute whose destination is the base-address register of a decode-stage store raises stall for one cycle.
- R7: Register 0 never matches any producer: it causes no stall, no select other than 2'b00 and no write-back bypass.
- R8: When the instruction in write-back writes a nonzero register read by the decode-stage instruction, the decode-stage bypass flag of that source is 1 in the same cycle.
- R9: In the cycle after a stall, both operand selects are 2'b00. Two cycles after a stall, the store-data bypass is 0.
- R10: Producers with the write flag clear never match. A source that the decode class does not read (source B of a load, any source of class 0) never matches.
- R11: During reset all registered selects and the store-data bypass read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_cls | input | 2 | Operation class of the decode-stage instruction |
| id_src_a | input | AW | Source A register (ALU operand A / base address) |
| id_src_b | input | AW | Source B register (ALU operand B / store data) |
| ex_dst | input | AW | Destination register of the execute-stage instruction |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_ld | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | AW | Destination register of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | AW | Destination register of the write-back instruction |
| wb_wr | input | 1 | Write-back instruction writes a register |
| stall | output | 1 | Hold program counter and fetch/decode register, bubble into execute |
| rf_fwd_a | output | 1 | Decode-stage read of source A takes the write-back value |
| rf_fwd_b | output | 1 | Decode-stage read of source B takes the write-back value |
| ex_sel_a | output | 2 | Execute operand A select: 00 file, 01 execute/memory, 10 memory/write-back |
| ex_sel_b | output | 2 | Execute operand B / store-data select, same encoding |
| mem_sd_sel | output | 1 | Memory-stage store data taken from the memory/write-back result |

## Verification
The case hardest to reach from the ports is a consistent stall: one cycle of stall must be followed by the same consumer being decoded again, with the load moved one stage on and a bubble in execute. Driving the port fields at random cannot reproduce that. The bench therefore keeps its own four-stage queue of instructions, advances it according to its model of the stall, and derives every port field from the queue contents. Short directed programs with few registers then force load-to-store-data, load-to-base, double-producer and register-0 cases. A longer random program over four registers mixes them.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  localparam int NSRC = 2;

  typedef enum logic [1:0] {
    CLS_NOP   = 2'd0,
    CLS_ALU   = 2'd1,
    CLS_LOAD  = 2'd2,
    CLS_STORE = 2'd3
  } op_cls_e;

  typedef enum logic [1:0] {
    SEL_RF    = 2'b00,
    SEL_EXMEM = 2'b01,
    SEL_MEMWB = 2'b10
  } fwd_sel_e;

endpackage

// File: rtl/hzd_rst_sync.sv
module hzd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) shift_q <= '0;
    else           shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = shift_q[STAGES-1];

endmodule

// File: rtl/hzd_src_match.sv
module hzd_src_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_wr,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_wr,
  output logic          hit_ex,
  output logic          hit_mem,
  output logic          hit_wb
);

  logic src_live;

  always_comb begin
    src_live = (src != '0);
    hit_ex   = src_live && ex_wr  && (ex_dst  == src);
    hit_mem  = src_live && mem_wr && (mem_dst == src);
    hit_wb   = src_live && wb_wr  && (wb_dst  == src);
  end

endmodule

// File: rtl/hzd_route.sv
module hzd_route
  import hzd_pkg::*;
(
  input  op_cls_e  cls,
  input  logic     ex_ld,
  input  logic     a_hit_ex,
  input  logic     a_hit_mem,
  input  logic     a_hit_wb,
  input  logic     b_hit_ex,
  input  logic     b_hit_mem,
  input  logic     b_hit_wb,
  output logic     stall,
  output fwd_sel_e sel_a,
  output fwd_sel_e sel_b,
  output logic     sd_late,
  output logic     rf_fwd_a,
  output logic     rf_fwd_b
);

  logic a_read;
  logic b_alu;
  logic b_store;
  logic b_read;

  always_comb begin
    a_read  = (cls != CLS_NOP);
    b_alu   = (cls == CLS_ALU);
    b_store = (cls == CLS_STORE);
    b_read  = b_alu || b_store;

    // a loaded value is late for execute, but not for the store-data slot
    stall = ex_ld && ((a_read && a_hit_ex) || (b_alu && b_hit_ex));

    sel_a = SEL_RF;
    if (a_read) begin
      if (a_hit_ex)       sel_a = SEL_EXMEM;
      else if (a_hit_mem) sel_a = SEL_MEMWB;
    end

    sel_b   = SEL_RF;
    sd_late = 1'b0;
    if (b_read) begin
      if (b_hit_ex) begin
        if (ex_ld) sd_late = b_store;
        else       sel_b   = SEL_EXMEM;
      end else if (b_hit_mem) begin
        sel_b = SEL_MEMWB;
      end
    end

    rf_fwd_a = a_read && a_hit_wb;
    rf_fwd_b = b_read && b_hit_wb;
  end

endmodule

// File: rtl/hzd_sel_pipe.sv
module hzd_sel_pipe
  import hzd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bubble,
  input  fwd_sel_e sel_a_in,
  input  fwd_sel_e sel_b_in,
  input  logic     sd_late_in,
  output fwd_sel_e sel_a_q,
  output fwd_sel_e sel_b_q,
  output logic     sd_mem_q
);

  fwd_sel_e sel_a_d;
  fwd_sel_e sel_b_d;
  logic     late_d;
  logic     late_q;
  logic     idex_en;

  assign idex_en = 1'b1;

  always_comb begin
    if (bubble) begin
      sel_a_d = SEL_RF;
      sel_b_d = SEL_RF;
      late_d  = 1'b0;
    end else begin
      sel_a_d = sel_a_in;
      sel_b_d = sel_b_in;
      late_d  = sd_late_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_a_q  <= SEL_RF;
      sel_b_q  <= SEL_RF;
      late_q   <= 1'b0;
      sd_mem_q <= 1'b0;
    end else if (idex_en) begin
      sel_a_q  <= sel_a_d;
      sel_b_q  <= sel_b_d;
      late_q   <= late_d;
      sd_mem_q <= late_q;
    end
  end

endmodule

// File: rtl/hzd_bypass_ctrl.sv
module hzd_bypass_ctrl
  import hzd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    id_cls,
  input  logic [AW-1:0] id_src_a,
  input  logic [AW-1:0] id_src_b,
  input  logic [AW-1:0] ex_dst,
  input  logic          ex_wr,
  input  logic          ex_ld,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_wr,
  output logic          stall,
  output logic          rf_fwd_a,
  output logic          rf_fwd_b,
  output logic [1:0]    ex_sel_a,
  output logic [1:0]    ex_sel_b,
  output logic          mem_sd_sel
);

  logic          rst_sync_n;
  logic [AW-1:0] src_vec [NSRC];
  logic          hit_ex  [NSRC];
  logic          hit_mem [NSRC];
  logic          hit_wb  [NSRC];
  op_cls_e       cls;
  fwd_sel_e      sel_a_c;
  fwd_sel_e      sel_b_c;
  fwd_sel_e      sel_a_r;
  fwd_sel_e      sel_b_r;
  logic          sd_late_c;
  logic          stall_c;

  hzd_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  assign src_vec[0] = id_src_a;
  assign src_vec[1] = id_src_b;
  assign cls        = op_cls_e'(id_cls);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hzd_src_match #(.AW(AW)) u_match (
      .src     (src_vec[g]),
      .ex_dst  (ex_dst),
      .ex_wr   (ex_wr),
      .mem_dst (mem_dst),
      .mem_wr  (mem_wr),
      .wb_dst  (wb_dst),
      .wb_wr   (wb_wr),
      .hit_ex  (hit_ex[g]),
      .hit_mem (hit_mem[g]),
      .hit_wb  (hit_wb[g])
    );
  end

  hzd_route u_route (
    .cls       (cls),
    .ex_ld     (ex_ld),
    .a_hit_ex  (hit_ex[0]),
    .a_hit_mem (hit_mem[0]),
    .a_hit_wb  (hit_wb[0]),
    .b_hit_ex  (hit_ex[1]),
    .b_hit_mem (hit_mem[1]),
    .b_hit_wb  (hit_wb[1]),
    .stall     (stall_c),
    .sel_a     (sel_a_c),
    .sel_b     (sel_b_c),
    .sd_late   (sd_late_c),
    .rf_fwd_a  (rf_fwd_a),
    .rf_fwd_b  (rf_fwd_b)
  );

  hzd_sel_pipe u_pipe (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bubble     (stall_c),
    .sel_a_in   (sel_a_c),
    .sel_b_in   (sel_b_c),
    .sd_late_in (sd_late_c),
    .sel_a_q    (sel_a_r),
    .sel_b_q    (sel_b_r),
    .sd_mem_q   (mem_sd_sel)
  );

  assign stall    = stall_c;
  assign ex_sel_a = sel_a_r;
  assign ex_sel_b = sel_b_r;

endmodule

// File: rtl/hzd_bypass_ctrl_chk.sv
module hzd_bypass_ctrl_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    id_cls,
  input logic [AW-1:0] id_src_a,
  input logic [AW-1:0] id_src_b,
  input logic [AW-1:0] ex_dst,
  input logic          ex_wr,
  input logic          ex_ld,
  input logic [AW-1:0] mem_dst,
  input logic          mem_wr,
  input logic [AW-1:0] wb_dst,
  input logic          wb_wr,
  input logic          stall,
  input logic          rf_fwd_a,
  input logic          rf_fwd_b,
  input logic [1:0]    ex_sel_a,
  input logic [1:0]    ex_sel_b,
  input logic          mem_sd_sel
);

  // R1
  alu_to_alu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_cls == 2'd1 && id_src_a != '0 && ex_wr && !ex_ld && ex_dst == id_src_a)
      |-> !stall ##1 (ex_sel_a == 2'b01));

  // R2
  sel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_sel_a != 2'b11) && (ex_sel_b != 2'b11));

  // R3
  younger_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_cls == 2'd1 && id_src_a != '0 && ex_wr && !ex_ld && ex_dst == id_src_a
     && mem_wr && mem_dst == id_src_a) |=> (ex_sel_a == 2'b01));

  // R4
  load_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_cls == 2'd1 && id_src_a != '0 && ex_wr && ex_ld && ex_dst == id_src_a) |-> stall);

  // R5
  load_store_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_cls == 2'd3 && id_src_b != '0 && ex_wr && ex_ld && ex_dst == id_src_b
     && ex_dst != id_src_a) |-> !stall ##2 mem_sd_sel);

  // R6
  load_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_cls == 2'd3 && id_src_a != '0 && ex_wr && ex_ld && ex_dst == id_src_a) |-> stall);

  // R7
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_src_a == '0 && id_src_b == '0) |-> (!stall && !rf_fwd_a && !rf_fwd_b));

  // R7
  zero_reg_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_src_a == '0 && id_src_b == '0) |=> (ex_sel_a == 2'b00 && ex_sel_b == 2'b00));

  // R8
  wb_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_fwd_a |-> (wb_wr && wb_dst == id_src_a && id_src_a != '0));

  // R9
  bubble_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (ex_sel_a == 2'b00 && ex_sel_b == 2'b00));

  // R9
  bubble_sd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> ##2 !mem_sd_sel);

  // R10
  no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_wr && !mem_wr) |=> (ex_sel_a == 2'b00 && ex_sel_b == 2'b00));

endmodule

bind hzd_bypass_ctrl hzd_bypass_ctrl_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .id_cls     (id_cls),
  .id_src_a   (id_src_a),
  .id_src_b   (id_src_b),
  .ex_dst     (ex_dst),
  .ex_wr      (ex_wr),
  .ex_ld      (ex_ld),
  .mem_dst    (mem_dst),
  .mem_wr     (mem_wr),
  .wb_dst     (wb_dst),
  .wb_wr      (wb_wr),
  .stall      (stall),
  .rf_fwd_a   (rf_fwd_a),
  .rf_fwd_b   (rf_fwd_b),
  .ex_sel_a   (ex_sel_a),
  .ex_sel_b   (ex_sel_b),
  .mem_sd_sel (mem_sd_sel)
);

// File: tb/hzd_bypass_ctrl_test.sv
`timescale 1ns/1ps
module hzd_bypass_ctrl_test;
  import hzd_pkg::*;

  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0]    id_cls;
  logic [AW-1:0] id_src_a, id_src_b, ex_dst, mem_dst, wb_dst;
  logic          ex_wr, ex_ld, mem_wr, wb_wr;
  logic          stall, rf_fwd_a, rf_fwd_b, mem_sd_sel;
  logic [1:0]    ex_sel_a, ex_sel_b;

  always #2.5 clk = ~clk;

  hzd_bypass_ctrl #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .id_cls(id_cls), .id_src_a(id_src_a), .id_src_b(id_src_b),
    .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_ld(ex_ld), .mem_dst(mem_dst), .mem_wr(mem_wr),
    .wb_dst(wb_dst), .wb_wr(wb_wr), .stall(stall), .rf_fwd_a(rf_fwd_a), .rf_fwd_b(rf_fwd_b),
    .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b), .mem_sd_sel(mem_sd_sel)
  );

  typedef struct {
    op_cls_e cls;
    int      a;
    int      b;
    int      d;
  } ins_t;

  ins_t s_id, s_ex, s_mem, s_wb;
  ins_t prog[$];

  int n_checks = 0;
  int n_fail   = 0;
  int exp_a = 0, exp_b = 0, exp_late = 0, exp_sd = 0;
  int st_cnt;
  bit saw_a01, saw_a10, saw_b01, saw_b10, saw_sd, saw_rfa, saw_rfb, any_sel, bub_bad, after_stall;

  function automatic ins_t mk(op_cls_e c, int d, int a, int b);
    ins_t i;
    i.cls = c; i.d = d; i.a = a; i.b = b;
    return i;
  endfunction

  // destination: ALU writes d, load writes its b field
  function automatic int dst_of(ins_t i);
    if (i.cls == CLS_ALU)  return i.d;
    if (i.cls == CLS_LOAD) return i.b;
    return 0;
  endfunction

  function automatic bit writes(ins_t i, int r);
    return (r != 0) && (i.cls == CLS_ALU || i.cls == CLS_LOAD) && (dst_of(i) == r);
  endfunction

  task automatic chk(input string tag, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic drive();
    id_cls   = s_id.cls;
    id_src_a = AW'(s_id.a);
    id_src_b = AW'(s_id.b);
    ex_dst   = AW'(dst_of(s_ex));
    ex_wr    = (s_ex.cls == CLS_ALU) || (s_ex.cls == CLS_LOAD);
    ex_ld    = (s_ex.cls == CLS_LOAD);
    mem_dst  = AW'(dst_of(s_mem));
    mem_wr   = (s_mem.cls == CLS_ALU) || (s_mem.cls == CLS_LOAD);
    wb_dst   = AW'(dst_of(s_wb));
    wb_wr    = (s_wb.cls == CLS_ALU) || (s_wb.cls == CLS_LOAD);
  endtask

  task automatic step();
    bit rd_a, rd_b, m_stall, rfa, rfb;
    int na, nb, nl;
    drive();
    #1;
    rd_a = (s_id.cls != CLS_NOP);
    rd_b = (s_id.cls == CLS_ALU) || (s_id.cls == CLS_STORE);
    m_stall = (s_ex.cls == CLS_LOAD) &&
              ((rd_a && writes(s_ex, s_id.a)) || (s_id.cls == CLS_ALU && writes(s_ex, s_id.b)));
    na = 0; nb = 0; nl = 0;
    if (rd_a) begin
      if (writes(s_ex, s_id.a))       na = 1;
      else if (writes(s_mem, s_id.a)) na = 2;
    end
    if (rd_b) begin
      if (writes(s_ex, s_id.b)) begin
        if (s_ex.cls == CLS_LOAD) nl = (s_id.cls == CLS_STORE) ? 1 : 0;
        else                      nb = 1;
      end else if (writes(s_mem, s_id.b)) nb = 2;
    end
    if (m_stall) begin na = 0; nb = 0; nl = 0; end
    rfa = rd_a && writes(s_wb, s_id.a);
    rfb = rd_b && writes(s_wb, s_id.b);

    chk("R4 R6 stall", int'(stall), int'(m_stall));
    chk("R8 rf_fwd_a", int'(rf_fwd_a), int'(rfa));
    chk("R8 rf_fwd_b", int'(rf_fwd_b), int'(rfb));
    chk("R1 R2 R3 R9 ex_sel_a", int'(ex_sel_a), exp_a);
    chk("R1 R2 R3 R9 ex_sel_b", int'(ex_sel_b), exp_b);
    chk("R5 R9 mem_sd_sel", int'(mem_sd_sel), exp_sd);

    if (stall) st_cnt++;
    if (ex_sel_a == 2'b01) saw_a01 = 1;
    if (ex_sel_a == 2'b10) saw_a10 = 1;
    if (ex_sel_b == 2'b01) saw_b01 = 1;
    if (ex_sel_b == 2'b10) saw_b10 = 1;
    if (mem_sd_sel) saw_sd = 1;
    if (rf_fwd_a) saw_rfa = 1;
    if (rf_fwd_b) saw_rfb = 1;
    if (ex_sel_a != 0 || ex_sel_b != 0 || mem_sd_sel) any_sel = 1;
    if (after_stall && (ex_sel_a != 0 || ex_sel_b != 0)) bub_bad = 1;
    after_stall = stall;

    @(posedge clk);
    exp_sd   = exp_late;
    exp_late = nl;
    exp_a    = na;
    exp_b    = nb;
    s_wb  = s_mem;
    s_mem = s_ex;
    if (m_stall) s_ex = mk(CLS_NOP, 0, 0, 0);
    else begin
      s_ex = s_id;
      s_id = (prog.size() > 0) ? prog.pop_front() : mk(CLS_NOP, 0, 0, 0);
    end
    @(negedge clk);
  endtask

  task automatic run();
    st_cnt = 0; saw_a01 = 0; saw_a10 = 0; saw_b01 = 0; saw_b10 = 0; saw_sd = 0;
    saw_rfa = 0; saw_rfb = 0; any_sel = 0; bub_bad = 0; after_stall = 0;
    while (prog.size() > 0) step();
    repeat (6) step();
  endtask

  initial begin
    #(5.0 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    s_id = mk(CLS_NOP, 0, 0, 0); s_ex = s_id; s_mem = s_id; s_wb = s_id;
    rst_n = 1'b0;
    drive();
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 ex_sel_a reset", int'(ex_sel_a), 0);
    chk("R11 ex_sel_b reset", int'(ex_sel_b), 0);
    chk("R11 mem_sd_sel reset", int'(mem_sd_sel), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: ALU result into a following ALU with no stall
    prog.push_back(mk(CLS_ALU, 1, 2, 3));
    prog.push_back(mk(CLS_ALU, 4, 1, 5));
    run();
    chk("R1 stall count", st_cnt, 0);
    chk("R1 saw select 01", int'(saw_a01), 1);

    // R2: producer two ahead selects memory/write-back
    prog.push_back(mk(CLS_ALU, 1, 2, 3));
    prog.push_back(mk(CLS_NOP, 0, 0, 0));
    prog.push_back(mk(CLS_ALU, 4, 5, 1));
    run();
    chk("R2 saw select 10 on B", int'(saw_b10), 1);

    // R3: both stages write r1, younger wins
    prog.push_back(mk(CLS_ALU, 1, 2, 3));
    prog.push_back(mk(CLS_ALU, 1, 1, 2));
    prog.push_back(mk(CLS_ALU, 3, 1, 1));
    run();
    chk("R3 saw 01", int'(saw_a01 && saw_b01), 1);
    chk("R3 older never chosen", int'(saw_a10), 0);

    // R4 and R9: load then dependent ALU
    prog.push_back(mk(CLS_LOAD, 0, 2, 1));
    prog.push_back(mk(CLS_ALU, 3, 1, 4));
    run();
    chk("R4 one stall", st_cnt, 1);
    chk("R4 operand from 10 after stall", int'(saw_a10), 1);
    chk("R9 bubble after stall", int'(bub_bad), 0);

    // R5: load feeding only store data
    prog.push_back(mk(CLS_LOAD, 0, 2, 1));
    prog.push_back(mk(CLS_STORE, 0, 3, 1));
    run();
    chk("R5 no stall", st_cnt, 0);
    chk("R5 store data bypass seen", int'(saw_sd), 1);

    // R6: load feeding store base
    prog.push_back(mk(CLS_LOAD, 0, 2, 1));
    prog.push_back(mk(CLS_STORE, 0, 1, 2));
    run();
    chk("R6 one stall", st_cnt, 1);

    // R7: register 0 never matches
    prog.push_back(mk(CLS_ALU, 0, 2, 3));
    prog.push_back(mk(CLS_ALU, 4, 0, 0));
    prog.push_back(mk(CLS_LOAD, 0, 2, 0));
    prog.push_back(mk(CLS_ALU, 5, 0, 0));
    prog.push_back(mk(CLS_NOP, 0, 0, 0));
    prog.push_back(mk(CLS_STORE, 0, 0, 0));
    run();
    chk("R7 no stall", st_cnt, 0);
    chk("R7 no bypass", int'(any_sel || saw_rfa || saw_rfb), 0);

    // R8: write-back producer read in decode
    prog.push_back(mk(CLS_ALU, 1, 2, 3));
    prog.push_back(mk(CLS_NOP, 0, 0, 0));
    prog.push_back(mk(CLS_NOP, 0, 0, 0));
    prog.push_back(mk(CLS_ALU, 2, 1, 1));
    run();
    chk("R8 both sources from write-back", int'(saw_rfa && saw_rfb), 1);

    // R10: load's B field unread, store writes nothing
    prog.push_back(mk(CLS_LOAD, 0, 2, 1));
    prog.push_back(mk(CLS_LOAD, 0, 3, 1));
    prog.push_back(mk(CLS_STORE, 0, 2, 4));
    prog.push_back(mk(CLS_ALU, 5, 4, 0));
    run();
    chk("R10 no stall", st_cnt, 0);
    chk("R10 no select from store", int'(saw_a01 || saw_b01), 0);

    // random mix over four registers
    for (int k = 0; k < 400; k++) begin
      prog.push_back(mk(op_cls_e'($urandom_range(0, 3)), $urandom_range(0, 3),
                        $urandom_range(0, 3), $urandom_range(0, 3)));
    end
    run();
    chk("R9 random bubbles", int'(bub_bad), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule